// File: doc/BRIEF.md
# Ethernet Transmit Framing Controller

This block turns one outgoing Ethernet frame into an ordered stream of bytes for a downstream serializer. When a protocol controller (which owns deferral and backoff) issues a start command, the block sends the preamble and the start-of-frame delimiter. It then passes payload bytes taken from a transmit FIFO, in order. If the frame's append option is set, it ends with a 4-byte frame check sequence computed by an attached CRC-32 unit.

A collision input makes the block stop sending frame content and send a fixed jam pattern instead. A collision that arrives while the preamble is going out is held until the delimiter has been sent. If the FIFO runs dry in the middle of the payload, the frame is also cut short with a jam. Each frame ends with a one-cycle completion pulse that carries the outcome: clean, collided or underrun.

Top module: `eth_tx_framer`

## Requirements
- R1: Every frame opens with PRE_LEN (default 7) bytes of 0x55 followed by one delimiter byte 0xD5, counted in accepted handshakes (`tx_valid_o && tx_ready_i`).
- R2: Payload bytes follow the delimiter in FIFO order. `fifo_rd_o` is high only in a cycle where a payload byte is accepted. The byte flagged by `fifo_last_i` ends the payload.
- R3: If `crc_en_i` was high in the start cycle, four FCS bytes follow the payload. They are the bitwise complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) over the payload, sent least significant byte first. If `crc_en_i` was low, the frame ends after the last payload byte.
- R4: A collision during payload or FCS holds back the byte on offer and sends JAM_LEN (default 4) bytes of 0xFF. The frame then ends with the collided flag set.
- R5: A collision during preamble or delimiter does not cut them short. The full preamble and the delimiter go out, then the jam, and the collided flag is set.
- R6: An empty FIFO while a payload byte is due ends the frame with the jam and sets the underrun flag. A collision in the same cycle takes priority and reports collided instead.
- R7: `stat_done_o` is high for exactly one cycle per frame. During that cycle `stat_col_o` and `stat_urun_o` give the outcome, and both are 0 for a clean frame.
- R8: `busy_o` rises the cycle after an accepted start and falls the cycle after `stat_done_o`. While `busy_o` is high, `start_i` and `crc_en_i` have no effect.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, the offered byte stays valid and unchanged, except when a collision withdraws it.
- R10: After reset, `tx_valid_o`, `fifo_rd_o`, `busy_o` and `stat_done_o` are low.
- R11: A collision that persists through the jam does not lengthen or restart it: exactly JAM_LEN jam bytes are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a frame (honoured only when idle) |
| crc_en_i | input | 1 | Append FCS to this frame, sampled with start |
| col_i | input | 1 | Collision indication from the medium |
| fifo_data_i | input | 8 | Payload byte at the FIFO head |
| fifo_valid_i | input | 1 | FIFO head holds a byte (not empty) |
| fifo_last_i | input | 1 | FIFO head byte is the last payload byte |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| tx_data_o | output | 8 | Byte offered to the serializer |
| tx_valid_o | output | 1 | Byte offered |
| tx_ready_i | input | 1 | Serializer accepts the byte |
| busy_o | output | 1 | A frame is in progress |
| stat_done_o | output | 1 | Completion pulse |
| stat_col_o | output | 1 | Frame ended by collision |
| stat_urun_o | output | 1 | Frame ended by FIFO underrun |

## Verification
The hardest cases are those where two frame-ending causes meet: a collision in the same cycle the FIFO runs dry, and a collision that starts in the preamble and is still active through the jam. The stimulus counts accepted output bytes and raises the collision level once that count reaches a chosen index. It keeps the collision high from then on. With this, a table entry can place the collision on a preamble byte, on the delimiter, on an FCS byte, or on the exact byte slot where an FIFO that is filled short would otherwise report underrun. A pseudo-random ready pattern stretches these windows across stalled cycles.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;

    localparam int BYTE_W = 8;
    localparam int FCS_LEN = 4;

    localparam logic [BYTE_W-1:0] PRE_BYTE = 8'h55;
    localparam logic [BYTE_W-1:0] SFD_BYTE = 8'hD5;
    localparam logic [BYTE_W-1:0] JAM_BYTE = 8'hFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_FCS,
        ST_JAM,
        ST_DONE
    } txf_state_e;

    typedef struct packed {
        logic col;
        logic urun;
    } txf_status_t;

    // One byte of reflected CRC-32, low bit of the byte first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc,
                                               input logic [BYTE_W-1:0] din);
        logic [31:0] c;
        c = crc;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else               c = c >> 1;
        end
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/txf_crc32.sv
module txf_crc32
    import eth_txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [31:0]       crc_o
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init_i) crc_q <= '1;
        else if (en_i)     crc_q <= crc32_step(crc_q, byte_i);
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/txf_seq.sv
module txf_seq
    import eth_txf_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int JAM_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              crc_en_i,
    input  logic              col_i,
    input  logic [BYTE_W-1:0] fifo_data_i,
    input  logic              fifo_valid_i,
    input  logic              fifo_last_i,
    output logic              fifo_rd_o,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    input  logic [31:0]       crc_i,
    output logic              crc_init_o,
    output logic              crc_en_o,
    output logic              busy_o,
    output logic              stat_done_o,
    output txf_status_t       stat_o
);

    localparam int MAX_RUN = max3(PRE_LEN, JAM_LEN, FCS_LEN);
    localparam int CNT_W   = (MAX_RUN > 1) ? $clog2(MAX_RUN) : 1;
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] JAM_LAST = CNT_W'(JAM_LEN - 1);
    localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_LEN - 1);

    txf_state_e  st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic        fcs_on_q, fcs_on_d;
    logic        col_pend_q, col_pend_d;
    txf_status_t stat_q, stat_d;

    logic        fire;
    logic [31:0] fcs_word;
    logic [31:0] fcs_shift;

    assign fire      = tx_valid_o && tx_ready_i;
    assign fcs_word  = ~crc_i;
    assign fcs_shift = fcs_word >> {cnt_q, 3'b000};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            fcs_on_q   <= 1'b0;
            col_pend_q <= 1'b0;
            stat_q     <= '0;
        end else begin
            st_q       <= st_d;
            cnt_q      <= cnt_d;
            fcs_on_q   <= fcs_on_d;
            col_pend_q <= col_pend_d;
            stat_q     <= stat_d;
        end
    end

    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q;
        fcs_on_d   = fcs_on_q;
        col_pend_d = col_pend_q;
        stat_d     = stat_q;
        tx_valid_o = 1'b0;
        tx_data_o  = '0;
        fifo_rd_o  = 1'b0;
        crc_init_o = 1'b0;
        crc_en_o   = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d       = ST_PRE;
                    cnt_d      = '0;
                    fcs_on_d   = crc_en_i;
                    col_pend_d = 1'b0;
                    stat_d     = '0;
                    crc_init_o = 1'b1;
                end
            end
            ST_PRE: begin
                tx_valid_o = 1'b1;
                tx_data_o  = PRE_BYTE;
                if (col_i) col_pend_d = 1'b1;
                if (fire) begin
                    if (cnt_q == PRE_LAST) begin
                        st_d  = ST_SFD;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SFD: begin
                tx_valid_o = 1'b1;
                tx_data_o  = SFD_BYTE;
                if (col_i) col_pend_d = 1'b1;
                if (fire) begin
                    cnt_d = '0;
                    if (col_pend_q || col_i) begin
                        st_d       = ST_JAM;
                        stat_d.col = 1'b1;
                    end else begin
                        st_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (col_i) begin
                    st_d       = ST_JAM;
                    cnt_d      = '0;
                    stat_d.col = 1'b1;
                end else if (!fifo_valid_i) begin
                    st_d        = ST_JAM;
                    cnt_d       = '0;
                    stat_d.urun = 1'b1;
                end else begin
                    tx_valid_o = 1'b1;
                    tx_data_o  = fifo_data_i;
                    if (fire) begin
                        fifo_rd_o = 1'b1;
                        crc_en_o  = 1'b1;
                        if (fifo_last_i) begin
                            st_d  = fcs_on_q ? ST_FCS : ST_DONE;
                            cnt_d = '0;
                        end
                    end
                end
            end
            ST_FCS: begin
                if (col_i) begin
                    st_d       = ST_JAM;
                    cnt_d      = '0;
                    stat_d.col = 1'b1;
                end else begin
                    tx_valid_o = 1'b1;
                    tx_data_o  = fcs_shift[BYTE_W-1:0];
                    if (fire) begin
                        if (cnt_q == FCS_LAST) begin
                            st_d  = ST_DONE;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
            end
            ST_JAM: begin
                tx_valid_o = 1'b1;
                tx_data_o  = JAM_BYTE;
                if (fire) begin
                    if (cnt_q == JAM_LAST) begin
                        st_d  = ST_DONE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    assign busy_o      = (st_q != ST_IDLE);
    assign stat_done_o = (st_q == ST_DONE);
    assign stat_o      = stat_q;

    // R1
    sfd_after_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PRE && fire && cnt_q == PRE_LAST) |=> (st_q == ST_SFD));

    // R2
    pop_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |-> (tx_valid_o && tx_ready_i && st_q == ST_DATA));

    // R5
    late_jam_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SFD && fire && (col_pend_q || col_i)) |=> (st_q == ST_JAM && stat_o.col));

    // R6
    underrun_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA && !fifo_valid_i && !col_i) |=> (st_q == ST_JAM && stat_o.urun && !stat_o.col));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stat_done_o |=> (!stat_done_o && !busy_o));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && $stable(stat_done_o)));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i && st_q != ST_DATA && !col_i)
            |=> (tx_valid_o && $stable(tx_data_o)));

    // R11
    jam_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_JAM && fire && cnt_q == JAM_LAST) |=> (st_q == ST_DONE));

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_txf_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int JAM_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       crc_en_i,
    input  logic       col_i,
    input  logic [7:0] fifo_data_i,
    input  logic       fifo_valid_i,
    input  logic       fifo_last_i,
    output logic       fifo_rd_o,
    output logic [7:0] tx_data_o,
    output logic       tx_valid_o,
    input  logic       tx_ready_i,
    output logic       busy_o,
    output logic       stat_done_o,
    output logic       stat_col_o,
    output logic       stat_urun_o
);

    logic        crc_init;
    logic        crc_en;
    logic [31:0] crc_val;
    txf_status_t stat;

    txf_crc32 u_crc (
        .clk    (clk),
        .rst    (rst),
        .init_i (crc_init),
        .en_i   (crc_en),
        .byte_i (fifo_data_i),
        .crc_o  (crc_val)
    );

    txf_seq #(
        .PRE_LEN (PRE_LEN),
        .JAM_LEN (JAM_LEN)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .crc_en_i     (crc_en_i),
        .col_i        (col_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_valid_i (fifo_valid_i),
        .fifo_last_i  (fifo_last_i),
        .fifo_rd_o    (fifo_rd_o),
        .tx_data_o    (tx_data_o),
        .tx_valid_o   (tx_valid_o),
        .tx_ready_i   (tx_ready_i),
        .crc_i        (crc_val),
        .crc_init_o   (crc_init),
        .crc_en_o     (crc_en),
        .busy_o       (busy_o),
        .stat_done_o  (stat_done_o),
        .stat_o       (stat)
    );

    assign stat_col_o  = stat.col;
    assign stat_urun_o = stat.urun;

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!tx_valid_o && !fifo_rd_o && !busy_o && !stat_done_o));

    // R4
    jam_after_col_chk: assert property (@(posedge clk) disable iff (rst)
        (col_i && busy_o && !stat_done_o && tx_valid_o && tx_data_o != 8'h55 && tx_data_o != 8'hD5 && tx_ready_i)
            |=> (tx_valid_o ? tx_data_o == 8'hFF : stat_done_o));

endmodule

// File: tb/eth_tx_framer_bench.sv
module eth_tx_framer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NONE = 255;

    typedef struct packed {
        logic [7:0] npay;
        logic [7:0] avail;
        logic       crc;
        logic [7:0] col_at;
        logic       bp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'd6,  8'd6,  1'b1, 8'd255, 1'b0},
        '{8'd5,  8'd5,  1'b0, 8'd255, 1'b1},
        '{8'd10, 8'd10, 1'b1, 8'd12,  1'b0},
        '{8'd4,  8'd4,  1'b1, 8'd13,  1'b1},
        '{8'd6,  8'd6,  1'b1, 8'd3,   1'b0},
        '{8'd6,  8'd3,  1'b1, 8'd255, 1'b1},
        '{8'd1,  8'd1,  1'b1, 8'd255, 1'b0},
        '{8'd8,  8'd2,  1'b0, 8'd10,  1'b0},
        '{8'd3,  8'd3,  1'b0, 8'd7,   1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       crc_en_i = 1'b0;
    logic       col_i;
    logic [7:0] fifo_data_i;
    logic       fifo_valid_i;
    logic       fifo_last_i;
    logic       fifo_rd_o;
    logic [7:0] tx_data_o;
    logic       tx_valid_o;
    logic       tx_ready_i = 1'b1;
    logic       busy_o;
    logic       stat_done_o;
    logic       stat_col_o;
    logic       stat_urun_o;

    int   n_checks = 0;
    int   n_fail = 0;

    logic [7:0] pay [64];
    logic [7:0] got [64];
    logic [7:0] expv [64];
    int   exp_len;
    bit   exp_col, exp_urun;
    int   out_cnt = 0, rd_ptr = 0, done_cnt = 0;
    int   cur_npay = 0, cur_avail = 0, cur_col_at = NONE;
    bit   col_arm = 1'b0, bp = 1'b0, mon_clr = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic prev_valid = 1'b0, prev_ready = 1'b0, prev_col = 1'b0;
    logic [7:0] prev_data = '0;
    int   hold_viol = 0;

    eth_tx_framer u_eth_tx_framer (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .crc_en_i     (crc_en_i),
        .col_i        (col_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_valid_i (fifo_valid_i),
        .fifo_last_i  (fifo_last_i),
        .fifo_rd_o    (fifo_rd_o),
        .tx_data_o    (tx_data_o),
        .tx_valid_o   (tx_valid_o),
        .tx_ready_i   (tx_ready_i),
        .busy_o       (busy_o),
        .stat_done_o  (stat_done_o),
        .stat_col_o   (stat_col_o),
        .stat_urun_o  (stat_urun_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        fifo_valid_i = (rd_ptr < cur_avail);
        fifo_last_i  = (rd_ptr == cur_npay - 1);
        fifo_data_i  = pay[rd_ptr[5:0]];
        col_i        = col_arm && (out_cnt >= cur_col_at);
    end

    always @(posedge clk) begin
        if (mon_clr) begin
            out_cnt  <= 0;
            rd_ptr   <= 0;
            done_cnt <= 0;
        end else begin
            if (tx_valid_o && tx_ready_i) begin
                got[out_cnt[5:0]] <= tx_data_o;
                out_cnt <= out_cnt + 1;
            end
            if (fifo_rd_o) rd_ptr <= rd_ptr + 1;
            if (stat_done_o) done_cnt <= done_cnt + 1;
        end
    end

    // Ready pattern and hold-stability monitor, both away from the rising edge.
    always @(negedge clk) begin
        if (!rst && prev_valid && !prev_ready && !prev_col)
            if (!tx_valid_o || tx_data_o != prev_data) hold_viol = hold_viol + 1;
        prev_valid = tx_valid_o;
        prev_data  = tx_data_o;
        prev_col   = col_i;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready_i = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
        prev_ready = tx_ready_i;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expd);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expd);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ pay[i][b];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic build_expect(input vec_t v);
        int norm_len, cut, upt, k;
        logic [31:0] f;
        for (int i = 0; i < 7; i++) expv[i] = 8'h55;
        expv[7] = 8'hD5;
        for (int i = 0; i < int'(v.npay); i++) expv[8+i] = pay[i];
        norm_len = 8 + int'(v.npay);
        if (v.crc) begin
            f = ref_crc(int'(v.npay));
            for (int i = 0; i < 4; i++) expv[norm_len+i] = f[8*i +: 8];
            norm_len += 4;
        end
        k   = int'(v.col_at);
        upt = (v.avail < v.npay) ? 8 + int'(v.avail) : NONE;
        exp_col = 1'b0; exp_urun = 1'b0; cut = norm_len;
        if (k != NONE && k < 8) begin
            cut = 8; exp_col = 1'b1;
        end else if (k != NONE && k <= upt && k < norm_len) begin
            cut = k; exp_col = 1'b1;
        end else if (upt != NONE) begin
            cut = upt; exp_urun = 1'b1;
        end
        if (exp_col || exp_urun) begin
            for (int i = 0; i < 4; i++) expv[cut+i] = 8'hFF;
            exp_len = cut + 4;
        end else begin
            exp_len = cut;
        end
    endtask

    task automatic run_frame(input vec_t v, input int idx, input bit poke);
        int bad_at;
        bit s_col, s_urun;
        for (int i = 0; i < 64; i++) pay[i] = 8'(i * 29 + 7 + idx * 3);
        build_expect(v);
        @(negedge clk);
        cur_npay   = int'(v.npay);
        cur_avail  = int'(v.avail);
        cur_col_at = int'(v.col_at);
        col_arm    = (v.col_at != 8'(NONE));
        bp         = v.bp;
        mon_clr    = 1'b1;
        @(negedge clk);
        mon_clr  = 1'b0;
        start_i  = 1'b1;
        crc_en_i = v.crc;
        @(negedge clk);
        start_i  = 1'b0;
        // R8: busy the cycle after start
        chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            start_i  = 1'b1;
            crc_en_i = ~v.crc;
            @(negedge clk);
            start_i  = 1'b0;
        end
        while (!stat_done_o) @(negedge clk);
        s_col  = stat_col_o;
        s_urun = stat_urun_o;
        @(negedge clk);
        // R8: busy drops the cycle after done
        chk(busy_o == 1'b0, "R8", "busy after done", busy_o, 0);
        repeat (3) @(negedge clk);
        col_arm = 1'b0;
        bp      = 1'b0;
        bad_at = -1;
        for (int i = 0; i < exp_len; i++)
            if (bad_at < 0 && got[i] !== expv[i]) bad_at = i;
        // R1 R2 R3 R4 R5 R6 R11: byte stream contents and length
        chk(out_cnt == exp_len, "R1/R3/R4/R11", $sformatf("frame %0d length", idx), out_cnt, exp_len);
        chk(bad_at < 0, "R1/R2/R3/R4", $sformatf("frame %0d byte %0d", idx, bad_at),
            (bad_at < 0) ? 0 : int'(got[bad_at]), (bad_at < 0) ? 0 : int'(expv[bad_at]));
        // R7 R5 R6: status fields
        chk(s_col == exp_col, "R7/R5", $sformatf("frame %0d collided flag", idx), s_col, exp_col);
        chk(s_urun == exp_urun, "R7/R6", $sformatf("frame %0d underrun flag", idx), s_urun, exp_urun);
        chk(done_cnt == 1, "R7", $sformatf("frame %0d done pulses", idx), done_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: quiet outputs while in reset
        chk(!tx_valid_o && !fifo_rd_o && !busy_o && !stat_done_o, "R10",
            "outputs in reset", {tx_valid_o, fifo_rd_o, busy_o, stat_done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_valid_o && !busy_o, "R10", "idle after reset", {tx_valid_o, busy_o}, 0);

        for (int i = 0; i < NVEC; i++) run_frame(VECS[i], i, 1'b0);

        // R8: start and crc option changes mid-frame are ignored
        run_frame(VECS[0], 20, 1'b1);
        run_frame(VECS[1], 21, 1'b1);

        // R11: collision from the SFD onward, held through the jam, with stalls
        run_frame('{8'd12, 8'd12, 1'b1, 8'd7, 1'b1}, 22, 1'b0);
        // R6: FIFO empty at the very first payload byte
        run_frame('{8'd5, 8'd0, 1'b1, 8'd255, 1'b0}, 23, 1'b0);
        // R3: collision on the last FCS byte
        run_frame('{8'd9, 8'd9, 1'b1, 8'd20, 1'b0}, 24, 1'b0);

        // R9: offered byte held steady under backpressure
        chk(hold_viol == 0, "R9", "hold violations", hold_viol, 0);

        // R10: reset in the middle of a frame returns to quiet
        @(negedge clk);
        cur_npay = 20; cur_avail = 20; mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0; start_i = 1'b1; crc_en_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!tx_valid_o && !busy_o && !fifo_rd_o && !stat_done_o, "R10",
            "quiet after mid-frame reset", {tx_valid_o, busy_o, fifo_rd_o, stat_done_o}, 0);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule